// File: doc/BRIEF.md
# Nested Rotating Bus Arbiter

This block decides which requester owns a shared system bus. Candidates are a host CPU, a group of expansion bus masters, a memory refresh controller and a DMA controller. The DMA controller presents one combined request. Arbitration is three levels deep:

- An outer ring of three slots: DMA, refresh and a host slot.
- Inside the host slot, a two-way ring that alternates between the CPU and the bus-master group.
- Inside the bus-master group, a ring over the individual masters.

An arbitration cycle runs when the current owner signals that it has released the bus. The winner is the first requesting candidate at or after each ring's pointer. Each pointer then moves just past the candidate that won, so the rotation order is fixed and a requester that is idle is skipped. When nothing requests, the CPU keeps the bus. While an NMI is pending, DMA and the bus masters are masked out, which leaves the bus to the CPU and refresh.

Grants are one-hot and registered. An arbitration strobe marks the cycle in which a new grant becomes visible.

Top module: `nested_bus_arbiter`

## Requirements
- R1: After reset, the CPU grant is high, all other grants are low and arb_strobe is low. All ring pointers start at their first entry: outer ring at DMA, host ring at CPU, bus-master ring at master 0.
- R2: Exactly one grant line is high in every cycle. Grants change only at a clock edge that raises arb_strobe.
- R3: A high bus_release at a clock edge runs one arbitration. In the next cycle arb_strobe is high and the new grant is visible. Without a release, arb_strobe is low.
- R4: The outer ring visits its slots in the order DMA (0), refresh (1), host (2), then back to DMA. After a win, its pointer moves to the slot after the winner.
- R5: A slot, host sub-slot or bus master that is not requesting is skipped. The search continues to the next requesting candidate in ring order.
- R6: Inside the host slot, the pointer alternates between CPU (0) and the bus-master group (1). After the CPU wins it points to the group; after a master wins it points to the CPU.
- R7: Within the group, the winner is the first requesting master at index ≥ the ring pointer, wrapping from NUM_BM-1 to 0. After the win, the pointer moves to the index after the winner.
- R8: If no eligible request is present at arbitration, the CPU is granted and no pointer moves.
- R9: While nmi_pend is high, DMA and bus-master requests are ignored at arbitration. Only the CPU or refresh can be granted.
- R10: With every requester asserting, the grant sequence from reset is fixed by rotation position alone: DMA, refresh, CPU, DMA, refresh, master 0, and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_release | input | 1 | Current owner releases the bus; starts an arbitration |
| cpu_req | input | 1 | Host CPU request |
| bm_req | input | NUM_BM | One request per expansion bus master |
| dma_req | input | 1 | Combined DMA controller request |
| rfsh_req | input | 1 | Refresh controller request |
| nmi_pend | input | 1 | NMI pending; masks DMA and bus masters |
| gnt_cpu | output | 1 | CPU owns the bus |
| gnt_bm | output | NUM_BM | One-hot bus-master grant |
| gnt_dma | output | 1 | DMA controller owns the bus |
| gnt_rfsh | output | 1 | Refresh controller owns the bus |
| arb_strobe | output | 1 | High in the cycle a new grant appears |

## Verification
The assertions check the following in every cycle:
- Grants are one-hot.
- Grants stay stable between strobes.
- The strobe follows a release by exactly one cycle.
- A slot whose request is low never receives a grant.
- The CPU receives the default grant when nothing requests.
- Under NMI, neither DMA nor a bus master is granted.
- The outer pointer stays in range.

Only the bench's scenarios can show the actual rotation order across many arbitrations. This covers the fully loaded sequence, skipping within each ring, alternation in the host slot, wrapping in the master ring and pointer restore on reset. These depend on state built up over earlier cycles, which a single-cycle property does not capture.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Outer ring slot codes; the order is the rotation order.
  localparam logic [1:0] SLOT_DMA  = 2'd0;
  localparam logic [1:0] SLOT_RFSH = 2'd1;
  localparam logic [1:0] SLOT_HOST = 2'd2;

  // Host ring sub-slot codes.
  localparam logic HOST_CPU = 1'b0;
  localparam logic HOST_BM  = 1'b1;

  // Index one past v in a ring of n entries.
  function automatic int wrap_inc(input int v, input int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // Index reached by stepping s positions from p in a ring of n.
  function automatic int ring_step(input int p, input int s, input int n);
    return (p + s) % n;
  endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          hit,
  output logic [IW-1:0] sel
);
  import arb_pkg::*;

  // Walk backwards so the nearest requester at or after ptr wins.
  always_comb begin
    hit = 1'b0;
    sel = ptr;
    for (int i = N - 1; i >= 0; i--) begin
      int k;
      k = ring_step(int'(ptr), i, N);
      if (req[k]) begin
        hit = 1'b1;
        sel = IW'(k);
      end
    end
  end

endmodule

// File: rtl/arb_select.sv
module arb_select #(
  parameter int NUM_BM = 4,
  localparam int BW = (NUM_BM > 1) ? $clog2(NUM_BM) : 1
) (
  input  logic              cpu_req,
  input  logic [NUM_BM-1:0] bm_req,
  input  logic              dma_req,
  input  logic              rfsh_req,
  input  logic              nmi_pend,
  input  logic [1:0]        top_ptr,
  input  logic              host_ptr,
  input  logic [BW-1:0]     bm_ptr,
  output logic              win_valid,
  output logic [1:0]        win_slot,
  output logic              win_host,
  output logic [BW-1:0]     win_bm
);

  logic dma_ok, rfsh_ok, cpu_ok, bm_ok, host_ok;
  logic host_hit, bm_hit;

  // NMI masks DMA and the bus-master group before any ring sees them.
  assign dma_ok  = dma_req & ~nmi_pend;
  assign rfsh_ok = rfsh_req;
  assign cpu_ok  = cpu_req;
  assign bm_ok   = (|bm_req) & ~nmi_pend;
  assign host_ok = cpu_ok | bm_ok;

  rr_pick #(.N(3)) u_top (
    .req ({host_ok, rfsh_ok, dma_ok}),
    .ptr (top_ptr),
    .hit (win_valid),
    .sel (win_slot)
  );

  rr_pick #(.N(2)) u_host (
    .req ({bm_ok, cpu_ok}),
    .ptr (host_ptr),
    .hit (host_hit),
    .sel (win_host)
  );

  rr_pick #(.N(NUM_BM)) u_bm (
    .req (bm_req),
    .ptr (bm_ptr),
    .hit (bm_hit),
    .sel (win_bm)
  );

  // Sub-ring hit flags are implied by host_ok; kept as named wires only.
  logic unused_hits;
  assign unused_hits = host_hit ^ bm_hit;

endmodule

// File: rtl/arb_state.sv
module arb_state #(
  parameter int NUM_BM = 4,
  localparam int BW = (NUM_BM > 1) ? $clog2(NUM_BM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_release,
  input  logic              win_valid,
  input  logic [1:0]        win_slot,
  input  logic              win_host,
  input  logic [BW-1:0]     win_bm,
  output logic [1:0]        top_ptr,
  output logic              host_ptr,
  output logic [BW-1:0]     bm_ptr,
  output logic              gnt_cpu,
  output logic [NUM_BM-1:0] gnt_bm,
  output logic              gnt_dma,
  output logic              gnt_rfsh,
  output logic              arb_strobe
);
  import arb_pkg::*;

  logic [NUM_BM-1:0] bm_dec;

  generate
    for (genvar g = 0; g < NUM_BM; g++) begin : g_bm_dec
      assign bm_dec[g] = (int'(win_bm) == g);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_ptr    <= SLOT_DMA;
      host_ptr   <= HOST_CPU;
      bm_ptr     <= '0;
      gnt_cpu    <= 1'b1;
      gnt_bm     <= '0;
      gnt_dma    <= 1'b0;
      gnt_rfsh   <= 1'b0;
      arb_strobe <= 1'b0;
    end else begin
      arb_strobe <= bus_release;
      if (bus_release) begin
        gnt_cpu  <= 1'b0;
        gnt_bm   <= '0;
        gnt_dma  <= 1'b0;
        gnt_rfsh <= 1'b0;
        if (!win_valid) begin
          gnt_cpu <= 1'b1;
        end else begin
          case (win_slot)
            SLOT_DMA: begin
              gnt_dma <= 1'b1;
              top_ptr <= SLOT_RFSH;
            end
            SLOT_RFSH: begin
              gnt_rfsh <= 1'b1;
              top_ptr  <= SLOT_HOST;
            end
            default: begin
              top_ptr <= SLOT_DMA;
              if (win_host == HOST_BM) begin
                gnt_bm   <= bm_dec;
                host_ptr <= HOST_CPU;
                bm_ptr   <= BW'(wrap_inc(int'(win_bm), NUM_BM));
              end else begin
                gnt_cpu  <= 1'b1;
                host_ptr <= HOST_BM;
              end
            end
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/nested_bus_arbiter.sv
module nested_bus_arbiter #(
  parameter int NUM_BM = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_release,
  input  logic              cpu_req,
  input  logic [NUM_BM-1:0] bm_req,
  input  logic              dma_req,
  input  logic              rfsh_req,
  input  logic              nmi_pend,
  output logic              gnt_cpu,
  output logic [NUM_BM-1:0] gnt_bm,
  output logic              gnt_dma,
  output logic              gnt_rfsh,
  output logic              arb_strobe
);
  localparam int BW = (NUM_BM > 1) ? $clog2(NUM_BM) : 1;

  logic [1:0]    top_ptr;
  logic          host_ptr;
  logic [BW-1:0] bm_ptr;
  logic          win_valid;
  logic [1:0]    win_slot;
  logic          win_host;
  logic [BW-1:0] win_bm;

  arb_select #(.NUM_BM(NUM_BM)) u_sel (
    .cpu_req   (cpu_req),
    .bm_req    (bm_req),
    .dma_req   (dma_req),
    .rfsh_req  (rfsh_req),
    .nmi_pend  (nmi_pend),
    .top_ptr   (top_ptr),
    .host_ptr  (host_ptr),
    .bm_ptr    (bm_ptr),
    .win_valid (win_valid),
    .win_slot  (win_slot),
    .win_host  (win_host),
    .win_bm    (win_bm)
  );

  arb_state #(.NUM_BM(NUM_BM)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_release (bus_release),
    .win_valid   (win_valid),
    .win_slot    (win_slot),
    .win_host    (win_host),
    .win_bm      (win_bm),
    .top_ptr     (top_ptr),
    .host_ptr    (host_ptr),
    .bm_ptr      (bm_ptr),
    .gnt_cpu     (gnt_cpu),
    .gnt_bm      (gnt_bm),
    .gnt_dma     (gnt_dma),
    .gnt_rfsh    (gnt_rfsh),
    .arb_strobe  (arb_strobe)
  );

endmodule

// File: rtl/nested_bus_arbiter_checker.sv
module nested_bus_arbiter_checker #(
  parameter int NUM_BM = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_release,
  input logic              cpu_req,
  input logic [NUM_BM-1:0] bm_req,
  input logic              dma_req,
  input logic              rfsh_req,
  input logic              nmi_pend,
  input logic              gnt_cpu,
  input logic [NUM_BM-1:0] gnt_bm,
  input logic              gnt_dma,
  input logic              gnt_rfsh,
  input logic              arb_strobe,
  input logic [1:0]        top_ptr
);
  logic [NUM_BM+2:0] gvec;
  assign gvec = {gnt_bm, gnt_rfsh, gnt_dma, gnt_cpu};

  a_r2_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gvec) == 1);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_strobe |-> $stable(gvec));

  a_r3_strobe_on: assert property (@(posedge clk) disable iff (!rst_n)
    bus_release |=> arb_strobe);

  a_r3_strobe_off: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_release |=> !arb_strobe);

  a_r5_no_dma_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_release && !dma_req) |=> !gnt_dma);

  a_r5_no_rfsh_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_release && !rfsh_req) |=> !gnt_rfsh);

  a_r8_default_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_release && !cpu_req && !rfsh_req && (nmi_pend || (!dma_req && bm_req == '0)))
      |=> gnt_cpu);

  a_r9_nmi_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_release && nmi_pend) |=> (!gnt_dma && gnt_bm == '0));

  a_r4_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    top_ptr != 2'd3);

endmodule

bind nested_bus_arbiter nested_bus_arbiter_checker #(.NUM_BM(NUM_BM)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_release (bus_release),
  .cpu_req     (cpu_req),
  .bm_req      (bm_req),
  .dma_req     (dma_req),
  .rfsh_req    (rfsh_req),
  .nmi_pend    (nmi_pend),
  .gnt_cpu     (gnt_cpu),
  .gnt_bm      (gnt_bm),
  .gnt_dma     (gnt_dma),
  .gnt_rfsh    (gnt_rfsh),
  .arb_strobe  (arb_strobe),
  .top_ptr     (top_ptr)
);

// File: tb/nested_bus_arbiter_bench.sv
module nested_bus_arbiter_bench;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_release = 1'b0;
  logic cpu_req = 1'b0;
  logic [NB-1:0] bm_req = '0;
  logic dma_req = 1'b0;
  logic rfsh_req = 1'b0;
  logic nmi_pend = 1'b0;
  logic gnt_cpu, gnt_dma, gnt_rfsh, arb_strobe;
  logic [NB-1:0] gnt_bm;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nested_bus_arbiter #(.NUM_BM(NB)) u_nested_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .bus_release(bus_release), .cpu_req(cpu_req),
    .bm_req(bm_req), .dma_req(dma_req), .rfsh_req(rfsh_req), .nmi_pend(nmi_pend),
    .gnt_cpu(gnt_cpu), .gnt_bm(gnt_bm), .gnt_dma(gnt_dma), .gnt_rfsh(gnt_rfsh),
    .arb_strobe(arb_strobe)
  );

  // Owner codes: 0 CPU, 1 DMA, 2 refresh, 3+k bus master k.
  function automatic logic [NB+2:0] owner_vec(input int code);
    logic [NB+2:0] v;
    v = '0;
    if (code == 0) v[0] = 1'b1;
    else if (code == 1) v[1] = 1'b1;
    else if (code == 2) v[2] = 1'b1;
    else v[code] = 1'b1;
    return v;
  endfunction

  // Entry: {cpu, bm[3:0], dma, rfsh, nmi, expected owner}
  localparam logic [11:0] VEC [0:24] = '{
    {1'b1, 4'hF, 1'b1, 1'b1, 1'b0, 4'd1},  // R10 R4 fully loaded
    {1'b1, 4'hF, 1'b1, 1'b1, 1'b0, 4'd2},
    {1'b1, 4'hF, 1'b1, 1'b1, 1'b0, 4'd0},  // R6 host starts at CPU
    {1'b1, 4'hF, 1'b1, 1'b1, 1'b0, 4'd1},
    {1'b1, 4'hF, 1'b1, 1'b1, 1'b0, 4'd2},
    {1'b1, 4'hF, 1'b1, 1'b1, 1'b0, 4'd3},  // R6 then group, master 0
    {1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 4'd2},  // R5 DMA skipped
    {1'b0, 4'h4, 1'b0, 1'b0, 1'b0, 4'd5},  // R7 pointer 1 -> master 2
    {1'b1, 4'h0, 1'b1, 1'b0, 1'b0, 4'd1},
    {1'b1, 4'h1, 1'b0, 1'b0, 1'b0, 4'd0},  // R6 host at CPU
    {1'b1, 4'h1, 1'b0, 1'b0, 1'b0, 4'd3},  // R7 wrap 3 -> 0
    {1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'd0},  // R8 default CPU
    {1'b1, 4'hF, 1'b1, 1'b1, 1'b1, 4'd2},  // R9 DMA bypassed
    {1'b1, 4'hF, 1'b1, 1'b1, 1'b1, 4'd0},  // R9 masters bypassed
    {1'b0, 4'hF, 1'b1, 1'b0, 1'b1, 4'd0},  // R9 R8 nothing eligible
    {1'b1, 4'hF, 1'b1, 1'b1, 1'b1, 4'd2},
    {1'b0, 4'hF, 1'b1, 1'b1, 1'b1, 4'd2},  // R9 host ineligible
    {1'b1, 4'hF, 1'b1, 1'b1, 1'b0, 4'd4},  // R8 R6 pointers kept: master 1
    {1'b0, 4'hB, 1'b0, 1'b0, 1'b0, 4'd6},  // R7 skip master 2
    {1'b0, 4'hB, 1'b0, 1'b0, 1'b0, 4'd3},
    {1'b0, 4'hB, 1'b0, 1'b0, 1'b0, 4'd4},
    {1'b0, 4'hB, 1'b0, 1'b0, 1'b0, 4'd6},
    {1'b0, 4'h0, 1'b1, 1'b1, 1'b0, 4'd1},
    {1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 4'd1},  // R5 wrap to DMA
    {1'b0, 4'h0, 1'b1, 1'b1, 1'b0, 4'd2}   // R4
  };

  task automatic check(input string req, input logic [NB+2:0] act, input logic [NB+2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic arbitrate(input logic [11:0] v, input string req);
    @(negedge clk);
    cpu_req = v[11]; bm_req = v[10:7]; dma_req = v[6]; rfsh_req = v[5]; nmi_pend = v[4];
    bus_release = 1'b1;
    @(negedge clk);
    bus_release = 1'b0;
    check(req, {gnt_bm, gnt_rfsh, gnt_dma, gnt_cpu}, owner_vec(int'(v[3:0])));
    check("R3 strobe high", {6'b0, arb_strobe}, 7'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset grant", {gnt_bm, gnt_rfsh, gnt_dma, gnt_cpu}, 7'b0000001);
    check("R1 reset strobe", {6'b0, arb_strobe}, 7'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 grant after reset", {gnt_bm, gnt_rfsh, gnt_dma, gnt_cpu}, 7'b0000001);

    for (int i = 0; i < 25; i++) arbitrate(VEC[i], $sformatf("R4-vector %0d", i));

    // R3: strobe drops one cycle after release goes low.
    @(negedge clk);
    check("R3 strobe low", {6'b0, arb_strobe}, 7'd0);

    // R2: request changes without release leave the grant (refresh) alone.
    cpu_req = 1'b1; bm_req = 4'hF; dma_req = 1'b1; rfsh_req = 1'b0;
    repeat (5) @(negedge clk);
    check("R2 grant held", {gnt_bm, gnt_rfsh, gnt_dma, gnt_cpu}, owner_vec(2));
    check("R2 no strobe", {6'b0, arb_strobe}, 7'd0);

    // R1: reset mid-run restores pointers.
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 mid reset", {gnt_bm, gnt_rfsh, gnt_dma, gnt_cpu}, 7'b0000001);
    rst_n = 1'b1;
    arbitrate({1'b1, 4'hF, 1'b1, 1'b1, 1'b0, 4'd1}, "R1 ptr restart DMA");
    arbitrate({1'b1, 4'hF, 1'b1, 1'b1, 1'b0, 4'd2}, "R1 ptr restart refresh");
    arbitrate({1'b1, 4'hF, 1'b1, 1'b1, 1'b0, 4'd0}, "R1 host ptr CPU");
    arbitrate({1'b0, 4'hF, 1'b0, 1'b0, 1'b0, 4'd3}, "R1 bm ptr master 0");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule